// File: doc/BRIEF.md
# Oscillator Calibration Sequencer

This block runs once before a digitally controlled oscillator loop is closed. It measures the two numbers that a feed-forward path needs: the frequency the oscillator runs at with a zero control word, and the slope of frequency against control word. It opens the loop through a select line and drives its own control words: first zero, then a first test word, then a second, larger test word. For each word it reads the frequency-to-digital converter and keeps one sample.

After each forced word it lets a programmable number of valid converter samples go by, so the oscillator can settle. It then keeps the next sample. From the two test readings it works out a fixed-point gain and its fixed-point reciprocal. Two sequential restoring dividers that run side by side produce these values. The results go into output registers for the loop controller, and a one-cycle done pulse marks the end of a run.

A run whose readings do not rise from the first test word to the second is rejected. So is a run whose test words are not in increasing order. In both cases an error flag is raised and the previous results are kept.

Top module: `osc_cal_seq`

## Requirements
- R1: In reset and right after it, busy, done, cal_err and loop_open are 0, and force_cw, free_freq, gain and inv_gain are all zero.
- R2: A start seen while the block is idle begins a run, and busy is 1 from the next cycle up to and including the done cycle. A start seen while busy is 1 is ignored.
- R3: loop_open is 1 from the first cycle after the run begins until the done cycle, and 0 in the done cycle. force_cw is 0 during the free-running interval, then the first test word, then the second test word until done. It is 0 whenever loop_open is 0.
- R4: In each of the three intervals the block lets settle_cnt cycles with meas_vld=1 go by and keeps meas from the next such cycle. meas is ignored in cycles where meas_vld=0 and in the first cycle of each interval.
- R5: On a successful run, free_freq takes the reading kept in the zero-word interval. The result outputs change only in a done cycle.
- R6: On a successful run, gain = floor((rb − ra)·2^GAIN_FRAC / (wb − wa)). Here ra and rb are the two kept test readings, and wa and wb are the two test words.
- R7: On a successful run, inv_gain = floor((wb − wa)·2^INV_FRAC / (rb − ra)).
- R8: On a successful run, done is 1 for exactly one cycle. The new results appear in that cycle, which starts NUM_MAX+2 cycles after the clock edge that keeps the last reading. NUM_MAX = max(FREQ_W+GAIN_FRAC, CW_W+INV_FRAC).
- R9: If rb ≤ ra or wb ≤ wa, cal_err is set and done pulses in the cycle right after the edge that keeps the last reading. The results keep their old values. The next start clears cal_err.
- R10: cw_a, cw_b and settle_cnt are taken at start. Changing them during a run has no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a calibration run |
| settle_cnt | input | SET_W | Valid samples to skip after each forced word |
| cw_a | input | CW_W | First test control word |
| cw_b | input | CW_W | Second test control word |
| meas | input | FREQ_W | Converter frequency reading |
| meas_vld | input | 1 | meas holds a new sample |
| loop_open | output | 1 | Selects the forced word ahead of the oscillator |
| force_cw | output | CW_W | Forced control word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| cal_err | output | 1 | Last run was rejected |
| free_freq | output | FREQ_W | Free-running frequency reading |
| gain | output | FREQ_W+GAIN_FRAC | Frequency step per control step, fixed point |
| inv_gain | output | CW_W+INV_FRAC | Reciprocal of gain, fixed point |

## Verification
The bench builds the block with CW_W=8, FREQ_W=12, SET_W=3, GAIN_FRAC=4 and INV_FRAC=8. Both dividers are then 16 bits wide, so each compute phase takes 18 cycles, and the largest skip count of 7 is within reach. A 3-bit skip count lets one run use every value of the skip counter up to its limit. The 8-bit words allow test words near both ends of their range, which gives nearly full-scale quotients on both dividers without overflowing the 12-bit readings.

// File: rtl/cal_pkg.sv
package cal_pkg;

  typedef enum logic [3:0] {
    CS_IDLE,
    CS_FORCE_ZERO,
    CS_MEAS_FREE,
    CS_FORCE_A,
    CS_MEAS_A,
    CS_FORCE_B,
    CS_MEAS_B,
    CS_COMPUTE,
    CS_DONE
  } cal_state_e;

  function automatic logic st_is_force(cal_state_e s);
    return (s == CS_FORCE_ZERO) || (s == CS_FORCE_A) || (s == CS_FORCE_B);
  endfunction

  function automatic logic st_is_meas(cal_state_e s);
    return (s == CS_MEAS_FREE) || (s == CS_MEAS_A) || (s == CS_MEAS_B);
  endfunction

  function automatic logic st_loop_open(cal_state_e s);
    return (s != CS_IDLE) && (s != CS_DONE);
  endfunction

endpackage

// File: rtl/cal_settle_gate.sv
module cal_settle_gate #(
  parameter int SET_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic [SET_W-1:0] settle,
  input  logic             en,
  input  logic             vld,
  output logic             take
);

  logic [SET_W-1:0] skip_left;

  assign take = en && vld && (skip_left == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_left <= '0;
    end else if (arm) begin
      skip_left <= settle;
    end else if (en && vld && (skip_left != '0)) begin
      skip_left <= skip_left - 1'b1;
    end
  end

endmodule

// File: rtl/cal_restoring_div.sv
module cal_restoring_div #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             busy
);

  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam logic [CNT_W-1:0] STEPS = CNT_W'(NUM_W);

  logic [DEN_W-1:0] rem;
  logic [NUM_W-1:0] nq;
  logic [CNT_W-1:0] steps_left;
  logic [DEN_W:0]   shifted;
  logic [DEN_W+1:0] trial;

  assign shifted = {rem, nq[NUM_W-1]};
  assign trial   = {1'b0, shifted} - {2'b00, den};
  assign quo     = nq;
  assign busy    = (steps_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rem        <= '0;
      nq         <= '0;
      steps_left <= '0;
    end else if (go) begin
      rem        <= '0;
      nq         <= num;
      steps_left <= STEPS;
    end else if (busy) begin
      steps_left <= steps_left - 1'b1;
      if (!trial[DEN_W+1]) begin
        rem <= trial[DEN_W-1:0];
        nq  <= {nq[NUM_W-2:0], 1'b1};
      end else begin
        rem <= shifted[DEN_W-1:0];
        nq  <= {nq[NUM_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/osc_cal_seq.sv
module osc_cal_seq
  import cal_pkg::*;
#(
  parameter int CW_W      = 10,
  parameter int FREQ_W    = 16,
  parameter int SET_W     = 4,
  parameter int GAIN_FRAC = 4,
  parameter int INV_FRAC  = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [SET_W-1:0]              settle_cnt,
  input  logic [CW_W-1:0]               cw_a,
  input  logic [CW_W-1:0]               cw_b,
  input  logic [FREQ_W-1:0]             meas,
  input  logic                          meas_vld,
  output logic                          loop_open,
  output logic [CW_W-1:0]               force_cw,
  output logic                          busy,
  output logic                          done,
  output logic                          cal_err,
  output logic [FREQ_W-1:0]             free_freq,
  output logic [FREQ_W+GAIN_FRAC-1:0]   gain,
  output logic [CW_W+INV_FRAC-1:0]      inv_gain
);

  localparam int GNUM_W = FREQ_W + GAIN_FRAC;
  localparam int INUM_W = CW_W + INV_FRAC;

  cal_state_e st, nxt;

  logic [CW_W-1:0]   cfg_a, cfg_b;
  logic [SET_W-1:0]  cfg_set;
  logic [FREQ_W-1:0] rd_free, rd_a, rd_b;
  logic              div_go;
  logic              take;
  logic              bad_run;
  logic              g_busy, i_busy;
  logic [GNUM_W-1:0] g_quo;
  logic [INUM_W-1:0] i_quo;
  logic [FREQ_W-1:0] d_freq;
  logic [CW_W-1:0]   d_word;
  logic              commit;

  cal_settle_gate #(.SET_W(SET_W)) u_gate (
    .clk    (clk),
    .rst    (rst),
    .arm    (st_is_force(st)),
    .settle (cfg_set),
    .en     (st_is_meas(st)),
    .vld    (meas_vld),
    .take   (take)
  );

  // The run is rejected if the readings do not rise or the words are out of order
  assign bad_run = (meas <= rd_a) || (cfg_b <= cfg_a);
  assign d_freq  = rd_b - rd_a;
  assign d_word  = cfg_b - cfg_a;

  cal_restoring_div #(.NUM_W(GNUM_W), .DEN_W(CW_W)) u_div_gain (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  ({d_freq, {GAIN_FRAC{1'b0}}}),
    .den  (d_word),
    .quo  (g_quo),
    .busy (g_busy)
  );

  cal_restoring_div #(.NUM_W(INUM_W), .DEN_W(FREQ_W)) u_div_inv (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  ({d_word, {INV_FRAC{1'b0}}}),
    .den  (d_freq),
    .quo  (i_quo),
    .busy (i_busy)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      CS_IDLE:       if (start) nxt = CS_FORCE_ZERO;
      CS_FORCE_ZERO: nxt = CS_MEAS_FREE;
      CS_MEAS_FREE:  if (take) nxt = CS_FORCE_A;
      CS_FORCE_A:    nxt = CS_MEAS_A;
      CS_MEAS_A:     if (take) nxt = CS_FORCE_B;
      CS_FORCE_B:    nxt = CS_MEAS_B;
      CS_MEAS_B:     if (take) nxt = bad_run ? CS_DONE : CS_COMPUTE;
      CS_COMPUTE:    if (!div_go && !g_busy && !i_busy) nxt = CS_DONE;
      CS_DONE:       nxt = CS_IDLE;
      default:       nxt = CS_IDLE;
    endcase
  end

  assign commit = (st == CS_COMPUTE) && (nxt == CS_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= CS_IDLE;
      cfg_a   <= '0;
      cfg_b   <= '0;
      cfg_set <= '0;
      rd_free <= '0;
      rd_a    <= '0;
      rd_b    <= '0;
      div_go  <= 1'b0;
      cal_err <= 1'b0;
    end else begin
      st     <= nxt;
      div_go <= (st == CS_MEAS_B) && take && !bad_run;
      if (st == CS_IDLE && start) begin
        cfg_a   <= cw_a;
        cfg_b   <= cw_b;
        cfg_set <= settle_cnt;
        cal_err <= 1'b0;
      end
      if (take) begin
        case (st)
          CS_MEAS_FREE: rd_free <= meas;
          CS_MEAS_A:    rd_a    <= meas;
          CS_MEAS_B:    begin
            rd_b <= meas;
            if (bad_run) cal_err <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // Outputs are registered from the next state so they line up with st
  always_ff @(posedge clk) begin
    if (rst) begin
      loop_open <= 1'b0;
      force_cw  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      loop_open <= st_loop_open(nxt);
      busy      <= (nxt != CS_IDLE);
      done      <= (nxt == CS_DONE);
      case (nxt)
        CS_FORCE_A, CS_MEAS_A:              force_cw <= cfg_a;
        CS_FORCE_B, CS_MEAS_B, CS_COMPUTE:  force_cw <= cfg_b;
        default:                            force_cw <= '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      free_freq <= '0;
      gain      <= '0;
      inv_gain  <= '0;
    end else if (commit) begin
      free_freq <= rd_free;
      gain      <= g_quo;
      inv_gain  <= i_quo;
    end
  end

endmodule

// File: rtl/osc_cal_seq_chk.sv
module osc_cal_seq_chk #(
  parameter int CW_W      = 10,
  parameter int FREQ_W    = 16,
  parameter int GAIN_FRAC = 4,
  parameter int INV_FRAC  = 12
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        start,
  input logic                        busy,
  input logic                        done,
  input logic                        loop_open,
  input logic [CW_W-1:0]             force_cw,
  input logic                        cal_err,
  input logic [FREQ_W-1:0]           free_freq,
  input logic [FREQ_W+GAIN_FRAC-1:0] gain,
  input logic [CW_W+INV_FRAC-1:0]    inv_gain
);

  AST_IDLE_START: assert property (@(posedge clk) disable iff (rst) (!busy && start) |=> busy); // R2
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> busy); // R2
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst) done |-> !loop_open); // R3
  AST_ZERO_WHEN_CLOSED: assert property (@(posedge clk) disable iff (rst) !loop_open |-> (force_cw == '0)); // R3
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> ($stable(free_freq) && $stable(gain) && $stable(inv_gain))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (rst) $rose(cal_err) |-> done); // R9

endmodule

bind osc_cal_seq osc_cal_seq_chk #(
  .CW_W(CW_W), .FREQ_W(FREQ_W), .GAIN_FRAC(GAIN_FRAC), .INV_FRAC(INV_FRAC)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .loop_open(loop_open), .force_cw(force_cw), .cal_err(cal_err),
  .free_freq(free_freq), .gain(gain), .inv_gain(inv_gain)
);

// File: tb/osc_cal_seq_test.sv
module osc_cal_seq_test;

  localparam int CW_W = 8, FREQ_W = 12, SET_W = 3, GAIN_FRAC = 4, INV_FRAC = 8;
  localparam int NUM_MAX = (FREQ_W + GAIN_FRAC > CW_W + INV_FRAC) ? FREQ_W + GAIN_FRAC : CW_W + INV_FRAC;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, meas_vld = 1'b0;
  logic [SET_W-1:0] settle_cnt = '0;
  logic [CW_W-1:0] cw_a = '0, cw_b = '0;
  logic [FREQ_W-1:0] meas = '0;
  logic loop_open, busy, done, cal_err;
  logic [CW_W-1:0] force_cw;
  logic [FREQ_W-1:0] free_freq;
  logic [FREQ_W+GAIN_FRAC-1:0] gain;
  logic [CW_W+INV_FRAC-1:0] inv_gain;

  osc_cal_seq #(.CW_W(CW_W), .FREQ_W(FREQ_W), .SET_W(SET_W),
                .GAIN_FRAC(GAIN_FRAC), .INV_FRAC(INV_FRAC)) uut (
    .clk(clk), .rst(rst), .start(start), .settle_cnt(settle_cnt),
    .cw_a(cw_a), .cw_b(cw_b), .meas(meas), .meas_vld(meas_vld),
    .loop_open(loop_open), .force_cw(force_cw), .busy(busy), .done(done),
    .cal_err(cal_err), .free_freq(free_freq), .gain(gain), .inv_gain(inv_gain)
  );

  always #5 clk = ~clk;

  int vectors = 0, fails = 0, cycles = 0;

  // Behavioural reference: phase numbers 0 idle .. 8 done
  int ph = 0, skip = 0, left = 0, ca = 0, cb = 0, sc = 0;
  int r0 = 0, ra = 0, rb = 0;
  int e_err = 0, e_free = 0, e_gain = 0, e_inv = 0;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      ph = 0; e_err = 0; e_free = 0; e_gain = 0; e_inv = 0;
    end else begin
      case (ph)
        0: if (start) begin ph = 1; ca = cw_a; cb = cw_b; sc = settle_cnt; e_err = 0; end
        1, 3, 5: begin ph = ph + 1; skip = sc; end
        2, 4, 6: if (meas_vld) begin
          if (skip > 0) skip--;
          else if (ph == 2) begin r0 = meas; ph = 3; end
          else if (ph == 4) begin ra = meas; ph = 5; end
          else begin
            rb = meas;
            if (rb <= ra || cb <= ca) begin e_err = 1; ph = 8; end
            else begin ph = 7; left = NUM_MAX + 2; end
          end
        end
        7: begin
          left--;
          if (left == 0) begin
            ph = 8; e_free = r0;
            e_gain = ((rb - ra) * (1 << GAIN_FRAC)) / (cb - ca);
            e_inv  = ((cb - ca) * (1 << INV_FRAC)) / (rb - ra);
          end
        end
        default: ph = 0;
      endcase
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int e_cw;
    e_cw = (ph == 3 || ph == 4) ? ca : (ph >= 5 && ph <= 7) ? cb : 0;
    vectors++;
    chk(rst ? "R1 loop_open" : "R3 loop_open", loop_open, (ph >= 1 && ph <= 7) ? 1 : 0);
    chk(rst ? "R1 force_cw" : "R3 force_cw", force_cw, e_cw);
    chk(rst ? "R1 busy" : "R2 busy", busy, (ph != 0) ? 1 : 0);
    chk(rst ? "R1 done" : "R8 done", done, (ph == 8) ? 1 : 0);
    chk(rst ? "R1 cal_err" : "R9 cal_err", cal_err, e_err);
    chk(rst ? "R1 free_freq" : "R5 R4 free_freq", free_freq, e_free);
    chk(rst ? "R1 gain" : "R6 R10 gain", gain, e_gain);
    chk(rst ? "R1 inv_gain" : "R7 inv_gain", inv_gain, e_inv);
  end

  // Converter model: reading follows the forced word, jitter marks which sample is kept
  int gen_base = 1000, gen_k = 0, gen_every = 1, gen_jit = 1, gen_idx = 0, gen_tick = 0;
  always @(negedge clk) begin
    #2;
    gen_tick++;
    if (gen_tick % gen_every == 0) begin
      meas_vld <= 1'b1;
      meas <= FREQ_W'(gen_base + gen_k * int'(force_cw) + (gen_jit ? (gen_idx % 4) : 0));
      gen_idx++;
    end else begin
      meas_vld <= 1'b0;
      meas <= FREQ_W'(gen_idx * 37);
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic run_cal(input int set, input int a, input int b, input int k,
                         input int every, input int jit, input int poke);
    @(negedge clk); #2;
    settle_cnt = SET_W'(set); cw_a = CW_W'(a); cw_b = CW_W'(b);
    gen_k = k; gen_every = every; gen_jit = jit;
    start = 1'b1;
    @(negedge clk); #2;
    start = 1'b0;
    if (poke != 0) begin
      // R10 and R2: new config and a second start during the run are ignored
      repeat (4) @(negedge clk);
      #2; start = 1'b1; cw_a = CW_W'(poke); cw_b = CW_W'(poke + 1); settle_cnt = '0;
      @(negedge clk); #2; start = 1'b0;
    end
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (ph == 0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2; rst = 1'b0;
    repeat (3) @(negedge clk);
    run_cal(2, 10, 60, 5, 3, 1, 0);      // R4 R5 R6 R7 R8 skip two samples, sparse valid
    run_cal(0, 100, 200, 3, 1, 1, 5);    // R10 R2 every cycle valid, config poked mid-run
    run_cal(1, 20, 90, 0, 2, 0, 0);      // R9 equal readings keep old results
    run_cal(1, 50, 50, 4, 1, 1, 0);      // R9 words not increasing
    run_cal(0, 30, 80, -2, 1, 0, 0);     // R9 falling readings
    run_cal(7, 3, 250, 7, 2, 1, 0);      // R4 R6 R7 largest skip, wide word span, clears R9 flag
    run_cal(3, 0, 1, 1, 1, 0, 0);        // R6 R7 single-step word span
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule